// File: doc/BRIEF.md
# Serial Keyboard Frame Decoder

This block receives a message from a keyboard microcontroller one bit at a time, with one bit offered on each scanline strobe. A frame opens with a 1 flag, which the block finds by hunting. Four don't-care bits follow, then a 3-bit type code, then a 16-bit body, and the frame closes with a 1 flag. The block checks the closing flag and then uses the type code to decide which result register takes the body.

There are four result registers for key state and one for the keyset and mouse switches. The block also keeps two running mouse-motion accumulators and two saturating error counters, one for frames with a bad closing flag and one for frames rejected as noise. A reserved all-ones body with the top type code raises a boot request, and the value of key-state word 0 at that moment is presented as its parameter. Each register update is marked by a one-cycle strobe on one wire.

Top module: `kbd_frame_decoder`

## Requirements
- R1: A synchronous active-high `rst` clears all key words, the switch word, both mouse accumulators, `boot_param`, `boot_req`, `upd_strobe` and both error counters, and it abandons any frame that is partly received.
- R2: A bit is taken only in a cycle with `bit_valid` high. While hunting, 0 bits are discarded and the first taken 1 starts a frame. `bit_in` has no effect while `bit_valid` is low.
- R3: The bits of a frame arrive in this order: leading 1, four ignored bits, type MSB first, body MSB first, trailing 1. Types 1, 2, 3 and 4 load the body into `key_word0`, `key_word1`, `key_word2` and `key_word3` respectively.
- R4: Type 5 loads the body into `switch_word`.
- R5: Type 6 treats body[15:8] as X motion and body[7:0] as Y motion, each in excess-128 code. The value minus 128 is added, modulo 2^16, to `mouse_x` and `mouse_y` respectively.
- R6: Type 7 with body 0xFFFF pulses `boot_req` high for one cycle and sets `boot_param` to the current `key_word0`. Any other type-7 frame changes no output.
- R7: Type 0 changes no result register and adds one to `reject_count`.
- R8: When the bit in the trailing-flag position is 0, the frame is discarded and `bad_end_count` gains one.
- R9: Both error counters stop at all ones and do not wrap.
- R10: Each accepted update pulses `upd_strobe` for exactly one cycle with one bit set: bits 0 to 3 for the key words, bit 4 for the switch word, bit 5 for the mouse. The registers and the strobe change on the clock edge after the edge that took the trailing bit.
- R11: After every frame, whether completed, rejected or discarded, the block hunts again, so a following frame may begin on the very next taken bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | Scanline strobe: take `bit_in` this cycle |
| bit_in | input | 1 | Serial message bit |
| key_word0 | output | 16 | Key-state word 0 |
| key_word1 | output | 16 | Key-state word 1 |
| key_word2 | output | 16 | Key-state word 2 |
| key_word3 | output | 16 | Key-state word 3 |
| switch_word | output | 16 | Keyset and mouse-switch word |
| mouse_x | output | 16 | Accumulated X motion |
| mouse_y | output | 16 | Accumulated Y motion |
| boot_req | output | 1 | One-cycle boot request |
| boot_param | output | 16 | Key word 0 captured at the boot request |
| upd_strobe | output | 6 | One-hot marker of the updated register |
| bad_end_count | output | 8 | Saturating count of bad closing flags |
| reject_count | output | 8 | Saturating count of type-0 frames |

## Verification
The hardest states to reach are the two counter ceilings, because each one needs 255 complete malformed frames before it shows. The stimulus drives 260 frames with a 0 closing flag and 260 frames of type 0, then checks that each counter has stopped at 255 and that nothing else moved. The frame boundary is also stressed. Leading zero bits and strobe-free gaps holding `bit_in` high are inserted inside frames. Two frames are sent with no idle bit between them. A reset is applied in the middle of a frame.

// File: rtl/kbd_frame_pkg.sv
package kbd_frame_pkg;
  localparam int TYPE_W = 3;
  localparam int KEY_WORDS = 4;
  localparam int UPD_W = KEY_WORDS + 2;
  localparam int UPD_SWITCH = KEY_WORDS;
  localparam int UPD_MOUSE = KEY_WORDS + 1;

  typedef enum logic [TYPE_W-1:0] {
    T_NOISE  = 3'd0,
    T_KEY0   = 3'd1,
    T_KEY1   = 3'd2,
    T_KEY2   = 3'd3,
    T_KEY3   = 3'd4,
    T_SWITCH = 3'd5,
    T_MOTION = 3'd6,
    T_SPECIAL = 3'd7
  } msg_type_e;
endpackage

// File: rtl/kbd_frame_shifter.sv
module kbd_frame_shifter
  import kbd_frame_pkg::*;
#(
  parameter int PAD_W  = 4,
  parameter int BODY_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_valid,
  input  logic              bit_in,
  output logic              done,
  output logic              flag_ok,
  output msg_type_e         typ,
  output logic [BODY_W-1:0] body
);
  localparam int PAY_W = PAD_W + TYPE_W + BODY_W;
  localparam int CNT_W = $clog2(PAY_W + 1);

  logic             hunting;
  logic [CNT_W-1:0] cnt;
  logic [PAY_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      hunting <= 1'b1;
      cnt     <= '0;
      shreg   <= '0;
      done    <= 1'b0;
      flag_ok <= 1'b0;
      typ     <= T_NOISE;
      body    <= '0;
    end else begin
      done <= 1'b0;
      if (bit_valid) begin
        if (hunting) begin
          if (bit_in) begin
            hunting <= 1'b0;
            cnt     <= '0;
          end
        end else if (cnt == CNT_W'(PAY_W)) begin
          done    <= 1'b1;
          flag_ok <= bit_in;
          typ     <= msg_type_e'(shreg[BODY_W +: TYPE_W]);
          body    <= shreg[BODY_W-1:0];
          hunting <= 1'b1;
        end else begin
          shreg <= {shreg[PAY_W-2:0], bit_in};
          cnt   <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/kbd_msg_dispatch.sv
module kbd_msg_dispatch
  import kbd_frame_pkg::*;
#(
  parameter int BODY_W = 16
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                done,
  input  logic                                flag_ok,
  input  msg_type_e                           typ,
  input  logic [BODY_W-1:0]                   body,
  output logic [KEY_WORDS-1:0][BODY_W-1:0]    keys,
  output logic [BODY_W-1:0]                   switch_word,
  output logic                                boot_req,
  output logic [BODY_W-1:0]                   boot_param,
  output logic [UPD_W-1:0]                    upd,
  output logic                                bad_inc,
  output logic                                reject_inc,
  output logic                                motion_en,
  output logic [BODY_W/2-1:0]                 dx_code,
  output logic [BODY_W/2-1:0]                 dy_code
);
  localparam int HALF = BODY_W / 2;

  logic accepted;
  logic boot_hit;

  always_comb begin
    accepted   = done && flag_ok;
    bad_inc    = done && !flag_ok;
    reject_inc = accepted && (typ == T_NOISE);
    motion_en  = accepted && (typ == T_MOTION);
    boot_hit   = accepted && (typ == T_SPECIAL) && (&body);
    dx_code    = body[BODY_W-1 -: HALF];
    dy_code    = body[HALF-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      keys        <= '0;
      switch_word <= '0;
      boot_req    <= 1'b0;
      boot_param  <= '0;
      upd         <= '0;
    end else begin
      upd      <= '0;
      boot_req <= boot_hit;
      if (boot_hit) boot_param <= keys[0];
      if (accepted) begin
        case (typ)
          T_KEY0:   begin keys[0] <= body; upd[0] <= 1'b1; end
          T_KEY1:   begin keys[1] <= body; upd[1] <= 1'b1; end
          T_KEY2:   begin keys[2] <= body; upd[2] <= 1'b1; end
          T_KEY3:   begin keys[3] <= body; upd[3] <= 1'b1; end
          T_SWITCH: begin switch_word <= body; upd[UPD_SWITCH] <= 1'b1; end
          T_MOTION: upd[UPD_MOTION_IDX] <= 1'b1;
          default:  ;
        endcase
      end
    end
  end

  localparam int UPD_MOTION_IDX = UPD_MOUSE;
endmodule

// File: rtl/kbd_motion_accum.sv
module kbd_motion_accum #(
  parameter int ACC_W  = 16,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [CODE_W-1:0] code,
  output logic [ACC_W-1:0]  acc
);
  localparam int EXT_W = ACC_W - CODE_W;

  logic [CODE_W-1:0] delta;
  logic [ACC_W-1:0]  delta_ext;

  always_comb begin
    delta     = code ^ {1'b1, {(CODE_W-1){1'b0}}};
    delta_ext = {{EXT_W{delta[CODE_W-1]}}, delta};
  end

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else if (en) acc <= acc + delta_ext;
  end
endmodule

// File: rtl/kbd_sat_counter.sv
module kbd_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else if (inc && !(&count)) count <= count + 1'b1;
  end
endmodule

// File: rtl/kbd_frame_decoder.sv
module kbd_frame_decoder
  import kbd_frame_pkg::*;
#(
  parameter int PAD_W  = 4,
  parameter int BODY_W = 16,
  parameter int ACC_W  = 16,
  parameter int ERR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_valid,
  input  logic              bit_in,
  output logic [BODY_W-1:0] key_word0,
  output logic [BODY_W-1:0] key_word1,
  output logic [BODY_W-1:0] key_word2,
  output logic [BODY_W-1:0] key_word3,
  output logic [BODY_W-1:0] switch_word,
  output logic [ACC_W-1:0]  mouse_x,
  output logic [ACC_W-1:0]  mouse_y,
  output logic              boot_req,
  output logic [BODY_W-1:0] boot_param,
  output logic [UPD_W-1:0]  upd_strobe,
  output logic [ERR_W-1:0]  bad_end_count,
  output logic [ERR_W-1:0]  reject_count
);
  localparam int HALF = BODY_W / 2;

  logic              done, flag_ok;
  msg_type_e         typ;
  logic [BODY_W-1:0] body;
  logic [KEY_WORDS-1:0][BODY_W-1:0] keys;
  logic              bad_inc, reject_inc, motion_en;
  logic [HALF-1:0]   dx_code, dy_code;

  logic [1:0]            err_inc;
  logic [1:0][ERR_W-1:0] err_cnt;
  logic [1:0][HALF-1:0]  mot_code;
  logic [1:0][ACC_W-1:0] mot_acc;

  kbd_frame_shifter #(.PAD_W(PAD_W), .BODY_W(BODY_W)) u_shift (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
    .done(done), .flag_ok(flag_ok), .typ(typ), .body(body)
  );

  kbd_msg_dispatch #(.BODY_W(BODY_W)) u_disp (
    .clk(clk), .rst(rst), .done(done), .flag_ok(flag_ok), .typ(typ),
    .body(body), .keys(keys), .switch_word(switch_word),
    .boot_req(boot_req), .boot_param(boot_param), .upd(upd_strobe),
    .bad_inc(bad_inc), .reject_inc(reject_inc), .motion_en(motion_en),
    .dx_code(dx_code), .dy_code(dy_code)
  );

  assign err_inc  = {reject_inc, bad_inc};
  assign mot_code = {dy_code, dx_code};

  for (genvar g = 0; g < 2; g++) begin : g_err
    kbd_sat_counter #(.W(ERR_W)) u_cnt (
      .clk(clk), .rst(rst), .inc(err_inc[g]), .count(err_cnt[g])
    );
  end

  for (genvar g = 0; g < 2; g++) begin : g_mot
    kbd_motion_accum #(.ACC_W(ACC_W), .CODE_W(HALF)) u_acc (
      .clk(clk), .rst(rst), .en(motion_en), .code(mot_code[g]),
      .acc(mot_acc[g])
    );
  end

  assign key_word0     = keys[0];
  assign key_word1     = keys[1];
  assign key_word2     = keys[2];
  assign key_word3     = keys[3];
  assign bad_end_count = err_cnt[0];
  assign reject_count  = err_cnt[1];
  assign mouse_x       = mot_acc[0];
  assign mouse_y       = mot_acc[1];
endmodule

// File: rtl/kbd_frame_decoder_chk.sv
module kbd_frame_decoder_chk #(
  parameter int BODY_W = 16,
  parameter int ACC_W  = 16,
  parameter int ERR_W  = 8,
  parameter int UPD_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [UPD_W-1:0]  upd_strobe,
  input logic              boot_req,
  input logic [ERR_W-1:0]  bad_end_count,
  input logic [ERR_W-1:0]  reject_count,
  input logic [BODY_W-1:0] key_word0,
  input logic [ACC_W-1:0]  mouse_x
);
  assert_upd_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(upd_strobe));

  assert_boot_single_R6: assert property (@(posedge clk) disable iff (rst)
    boot_req |=> !boot_req);

  assert_bad_step_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(bad_end_count) |->
      ($past(rst) || ({1'b0, bad_end_count} == {1'b0, $past(bad_end_count)} + 1'b1)));

  assert_reject_step_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(reject_count) |->
      ($past(rst) || ({1'b0, reject_count} == {1'b0, $past(reject_count)} + 1'b1)));

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (bad_end_count == '0 && reject_count == '0 && upd_strobe == '0 && !boot_req));

  assert_key0_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(key_word0) |-> ($past(rst) || upd_strobe[0]));

  assert_mouse_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(mouse_x) |-> ($past(rst) || upd_strobe[UPD_W-1]));
endmodule

bind kbd_frame_decoder kbd_frame_decoder_chk #(
  .BODY_W(BODY_W), .ACC_W(ACC_W), .ERR_W(ERR_W), .UPD_W(kbd_frame_pkg::UPD_W)
) u_chk (.*);

// File: tb/kbd_frame_decoder_test.sv
`timescale 1ns/1ps
module kbd_frame_decoder_test;
  localparam int PAD_W = 4, BODY_W = 16, ACC_W = 16, ERR_W = 8;

  logic clk = 1'b0, rst = 1'b1, bit_valid = 1'b0, bit_in = 1'b0;
  logic [15:0] key_word0, key_word1, key_word2, key_word3, switch_word;
  logic [15:0] mouse_x, mouse_y, boot_param;
  logic boot_req;
  logic [5:0] upd_strobe;
  logic [7:0] bad_end_count, reject_count;

  kbd_frame_decoder #(.PAD_W(PAD_W), .BODY_W(BODY_W), .ACC_W(ACC_W), .ERR_W(ERR_W)) uut (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
    .key_word0(key_word0), .key_word1(key_word1), .key_word2(key_word2),
    .key_word3(key_word3), .switch_word(switch_word), .mouse_x(mouse_x),
    .mouse_y(mouse_y), .boot_req(boot_req), .boot_param(boot_param),
    .upd_strobe(upd_strobe), .bad_end_count(bad_end_count),
    .reject_count(reject_count)
  );

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0;
  logic [15:0] e_key [4];
  logic [15:0] e_sw, e_mx, e_my, e_bp;
  int e_bad = 0, e_rej = 0, e_boots = 0;
  int boots = 0, upd_pulses = 0;
  logic [5:0] last_upd = '0;

  always @(negedge clk) if (!rst) begin
    if (upd_strobe != '0) begin upd_pulses++; last_upd = upd_strobe; end
    if (boot_req) boots++;
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 4; i++) e_key[i] = '0;
    e_sw = '0; e_mx = '0; e_my = '0; e_bp = '0; e_bad = 0; e_rej = 0;
  endtask

  task automatic check_all(string req);
    chk({req, " key0"}, key_word0, e_key[0]);
    chk({req, " key1"}, key_word1, e_key[1]);
    chk({req, " key2"}, key_word2, e_key[2]);
    chk({req, " key3"}, key_word3, e_key[3]);
    chk({req, " switch"}, switch_word, e_sw);
    chk({req, " mouse_x"}, mouse_x, e_mx);
    chk({req, " mouse_y"}, mouse_y, e_my);
    chk({req, " boot_param"}, boot_param, e_bp);
    chk({req, " boot pulses"}, boots, e_boots);
    chk({req, " bad_end_count"}, bad_end_count, e_bad);
    chk({req, " reject_count"}, reject_count, e_rej);
  endtask

  task automatic put_bit(logic b);
    bit_valid = 1'b1; bit_in = b;
    @(negedge clk);
    bit_valid = 1'b0; bit_in = 1'b0;
  endtask

  task automatic gap(int n);
    bit_valid = 1'b0; bit_in = 1'b1;
    repeat (n) @(negedge clk);
    bit_in = 1'b0;
  endtask

  task automatic send(int t, logic [15:0] body, logic trail, int g);
    put_bit(1'b1);
    for (int i = 0; i < PAD_W; i++) begin put_bit(i[0] ^ t[0]); gap(g); end
    for (int i = 2; i >= 0; i--) begin put_bit(t[i]); gap(g); end
    for (int i = 15; i >= 0; i--) begin put_bit(body[i]); gap(g); end
    put_bit(trail);
  endtask

  task automatic apply(int t, logic [15:0] body, logic trail, output logic [5:0] eu);
    eu = '0;
    if (!trail) begin
      if (e_bad < 255) e_bad++;
    end else begin
      case (t)
        0: if (e_rej < 255) e_rej++;
        1, 2, 3, 4: begin e_key[t-1] = body; eu = 6'(1 << (t-1)); end
        5: begin e_sw = body; eu = 6'b010000; end
        6: begin
          e_mx = e_mx + 16'($signed({1'b0, body[15:8]}) - 128);
          e_my = e_my + 16'($signed({1'b0, body[7:0]}) - 128);
          eu = 6'b100000;
        end
        default: if (body == 16'hFFFF) begin e_bp = e_key[0]; e_boots++; end
      endcase
    end
  endtask

  function automatic string req_of(int t, logic trail);
    if (!trail) return "R8";
    case (t)
      0: return "R7";
      5: return "R4";
      6: return "R5";
      7: return "R6";
      default: return "R3";
    endcase
  endfunction

  task automatic run_frame(int t, logic [15:0] body, logic trail, int g);
    int p0;
    logic [5:0] eu;
    p0 = upd_pulses;
    last_upd = '0;
    send(t, body, trail, g);
    repeat (3) @(negedge clk);
    apply(t, body, trail, eu);
    check_all(req_of(t, trail));
    chk("R10 strobe count", upd_pulses - p0, (eu != 0) ? 1 : 0);
    chk("R10 strobe bit", last_upd, eu);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired got=1 exp=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] b;
    logic [5:0] eu;
    int p0;
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all("R1 reset");
    chk("R1 reset strobe", upd_strobe, 0);

    for (int t = 0; t < 8; t++) begin
      for (int k = 0; k < 6; k++) begin
        case (k)
          0: b = 16'h0000;
          1: b = 16'hFFFF;
          2: b = 16'h8080;
          3: b = 16'h7F01;
          4: b = 16'(16'h1357 * (t + 1));
          default: b = 16'(16'hA5C3 ^ (t * 16'h0F21));
        endcase
        run_frame(t, b, 1'b1, k % 3);
      end
    end

    // R6: boot with a known key word, then a near-miss type 7
    run_frame(1, 16'h1234, 1'b1, 0);
    run_frame(7, 16'hFFFF, 1'b1, 1);
    run_frame(7, 16'hFFFE, 1'b1, 0);
    run_frame(7, 16'h7FFF, 1'b1, 2);

    // R8: bad closing flag on several types
    run_frame(1, 16'hDEAD, 1'b0, 0);
    run_frame(6, 16'h00FF, 1'b0, 1);
    run_frame(7, 16'hFFFF, 1'b0, 0);

    // R2: zeros while hunting, strobe-free gaps with bit_in high
    for (int i = 0; i < 9; i++) put_bit(1'b0);
    gap(5);
    run_frame(3, 16'hBEEF, 1'b1, 2);

    // R11: back-to-back frames with no idle bit between them
    p0 = upd_pulses;
    send(2, 16'h4242, 1'b1, 0);
    send(5, 16'h0F0F, 1'b1, 0);
    repeat (3) @(negedge clk);
    apply(2, 16'h4242, 1'b1, eu);
    apply(5, 16'h0F0F, 1'b1, eu);
    check_all("R11 back-to-back");
    chk("R11 two strobes", upd_pulses - p0, 2);

    // R9: counter ceilings
    for (int i = 0; i < 260; i++) begin
      send(4, 16'(i), 1'b0, 0);
      apply(4, 16'(i), 1'b0, eu);
    end
    for (int i = 0; i < 260; i++) begin
      send(0, 16'(i), 1'b1, 0);
      apply(0, 16'(i), 1'b1, eu);
    end
    repeat (3) @(negedge clk);
    check_all("R9 saturation");
    chk("R9 bad ceiling", bad_end_count, 8'hFF);
    chk("R9 reject ceiling", reject_count, 8'hFF);

    // R1: reset in the middle of a frame
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_clear();
    @(negedge clk);
    check_all("R1 mid reset");
    run_frame(4, 16'h5A5A, 1'b1, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule